// File: doc/BRIEF.md
# Command/Address Bus Delay Training Sequencer

This controller-side sequencer calibrates the input delay of each pin of a double-data-rate command/address (CA) bus. It first puts the memory into training mode with a mode register write. Then it trains the pins one at a time. For each pin it steps a delay tap across its full range. At each tap it drives a single-pin test pattern on the rising and falling halves of the clock. After a fixed settling time it compares the 16-bit data readback with what was driven.

The memory reports the value captured on the rising edge on an even data line and the value captured on the falling edge on the next odd data line. Calibration runs in two sessions. A mode register write between them changes which CA pins appear on the data bus. For each pin the sequencer keeps the longest contiguous run of passing taps and reports the run's midpoint. A pin that never passes is flagged as failed and is left at the default tap. A final mode register write leaves training mode, and done is raised.

The sequencer only produces an abstract command stream, a tap value and a pattern. Delay lines, pad timing and the memory device are outside this block.

Top module: `ca_train_seq`

## Requirements
- R1: After reset, `done_o` is 0, `cmd_op_o` is NOP (0), every `fail_o` bit is 0 and every centre field reads the default tap 16.
- R2: A `start_i` pulse while idle or done makes the first command a mode register write (`cmd_op_o`=1) to address 41.
- R3: Session one trains the pins in the order CA0, CA1, CA2, CA3, CA5, CA6, CA7, CA8. The n-th pin of this list (n=0..7) is read back on DQ[2n] (rising) and DQ[2n+1] (falling).
- R4: After session one, a mode register write to address 48 is issued. Session two then trains CA4, read on DQ0/DQ1, followed by CA9, read on DQ2/DQ3.
- R5: After the last pin, a mode register write to address 42 is issued, and in the next cycle `done_o` rises and stays high until the next start.
- R6: In every mode register write cycle, `pat_rise_o` equals `pat_fall_o`.
- R7: Training cycles (`cmd_op_o`=2) step the tap in ascending order from 0 to 31 for each pin. Each tap gets phase A (only the trained pin is high on rise and low on fall) and then phase B (low on rise, high on fall). All other pins are low.
- R8: Each pattern is held for exactly SETTLE_CYC cycles before the data bus is sampled in the following cycle. Readback that is earlier than this has no effect on the result.
- R9: A tap passes only if, in both phases, both the even and the odd readback lines match the driven values.
- R10: The chosen window is the longest contiguous run of passing taps, with the earliest run winning a tie. The centre is floor((first+last)/2) and is reported in `center_o[5p+4:5p]` for pin CAp.
- R11: A pin with no passing tap gets `fail_o[p]`=1 and a centre of 16. A later successful run clears the flag.
- R12: `start_i` is ignored while a training run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a training run |
| dq_i | input | 16 | Sampled data-bus readback |
| cmd_op_o | output | 2 | Command: 0 NOP, 1 mode register write, 2 training pattern |
| cmd_mr_o | output | 8 | Mode register address for writes |
| tap_o | output | 5 | Delay tap applied to the pin under training |
| pat_rise_o | output | 10 | CA values driven on the rising edge |
| pat_fall_o | output | 10 | CA values driven on the falling edge |
| done_o | output | 1 | Run complete, results valid |
| center_o | output | 50 | Per-pin centre tap, 5 bits per pin |
| fail_o | output | 10 | Per-pin no-window flag |

## Verification
The memory model in the bench returns wrong data until a pattern has been stable for the settling time, so a sequencer that samples too early reports shifted or missing windows. Pin windows are chosen to tell the rules apart: two runs where the later one is longer, two runs of equal length, windows that touch tap 0 or tap 31, a pin with no passing tap, and a pin whose odd line passes over a narrower range than its even line. A design that keeps the first run, breaks ties toward the later run, rounds up, or checks only one line gets a different centre. The model applies the session-two pin mapping only after it sees the remap write, so wrong pin order or wrong slot use shows up as failed pins. A start pulse during a run must not produce a second entry write.

// File: rtl/ca_train_pkg.sv
package ca_train_pkg;
  typedef enum logic [1:0] {OP_NOP = 2'd0, OP_MRW = 2'd1, OP_TRAIN = 2'd2} ca_op_e;

  localparam logic [7:0] MR_ENTER = 8'd41;
  localparam logic [7:0] MR_EXIT  = 8'd42;
  localparam logic [7:0] MR_REMAP = 8'd48;

  localparam int CA_PINS    = 10;
  localparam int SESS1_PINS = 8;
  localparam int DQ_W       = 16;
  localparam int SLOT_W     = 3;

  // training order: session one then session two
  function automatic logic [3:0] seq_pin(input logic [3:0] idx);
    case (idx)
      4'd4:    return 4'd5;
      4'd5:    return 4'd6;
      4'd6:    return 4'd7;
      4'd7:    return 4'd8;
      4'd8:    return 4'd4;
      4'd9:    return 4'd9;
      default: return idx;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] seq_slot(input logic [3:0] idx);
    logic [3:0] s;
    s = (idx < 4'(SESS1_PINS)) ? idx : idx - 4'(SESS1_PINS);
    return s[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/ca_slot_compare.sv
module ca_slot_compare #(
  parameter int DQ_W   = 16,
  parameter int SLOT_W = 3
) (
  input  logic [DQ_W-1:0]   dq_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              match_o
);
  localparam int SLOTS = DQ_W / 2;

  logic [SLOTS-1:0] even_l, odd_l;

  for (genvar g = 0; g < SLOTS; g++) begin : g_split
    assign even_l[g] = dq_i[2*g];
    assign odd_l[g]  = dq_i[2*g+1];
  end

  assign match_o = (even_l[slot_i] == rise_i) && (odd_l[slot_i] == fall_i);
endmodule

// File: rtl/ca_window_track.sv
module ca_window_track #(
  parameter int TAP_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             found_o,
  output logic [TAP_W-1:0] first_o,
  output logic [TAP_W-1:0] last_o
);
  logic             run_on_q;
  logic [TAP_W-1:0] run_start_q;
  logic [TAP_W:0]   run_len_q, best_len_q;
  logic [TAP_W-1:0] nxt_start;
  logic [TAP_W:0]   nxt_len;

  assign nxt_start = run_on_q ? run_start_q : tap_i;
  assign nxt_len   = run_on_q ? run_len_q + 1'b1 : (TAP_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_on_q    <= 1'b0;
      run_start_q <= '0;
      run_len_q   <= '0;
      best_len_q  <= '0;
      first_o     <= '0;
      last_o      <= '0;
    end else if (clr_i) begin
      run_on_q    <= 1'b0;
      run_start_q <= '0;
      run_len_q   <= '0;
      best_len_q  <= '0;
      first_o     <= '0;
      last_o      <= '0;
    end else if (step_i) begin
      if (pass_i) begin
        run_on_q    <= 1'b1;
        run_start_q <= nxt_start;
        run_len_q   <= nxt_len;
        // strict compare keeps the earliest run on a tie
        if (nxt_len > best_len_q) begin
          best_len_q <= nxt_len;
          first_o    <= nxt_start;
          last_o     <= tap_i;
        end
      end else begin
        run_on_q  <= 1'b0;
        run_len_q <= '0;
      end
    end
  end

  assign found_o = best_len_q != '0;

  p_window_span_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> ((TAP_W+1)'(last_o - first_o) + 1'b1 == best_len_q));

  p_run_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_len_q <= best_len_q);
endmodule

// File: rtl/ca_train_seq.sv
module ca_train_seq
  import ca_train_pkg::*;
#(
  parameter int TAP_W      = 5,
  parameter int SETTLE_CYC = 3,
  parameter int DEF_TAP    = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [15:0]              dq_i,
  output logic [1:0]               cmd_op_o,
  output logic [7:0]               cmd_mr_o,
  output logic [TAP_W-1:0]         tap_o,
  output logic [9:0]               pat_rise_o,
  output logic [9:0]               pat_fall_o,
  output logic                     done_o,
  output logic [10*TAP_W-1:0]      center_o,
  output logic [9:0]               fail_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [TAP_W-1:0] TAP_DEF = TAP_W'(DEF_TAP);

  typedef enum logic [2:0] {
    S_IDLE, S_ENTER, S_DRIVE, S_STORE, S_REMAP, S_EXIT, S_DONE
  } st_e;

  st_e              state_q;
  logic [3:0]       idx_q;
  logic [TAP_W-1:0] tap_q;
  logic             phase_q, ph_ok_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TAP_W-1:0] center_q [CA_PINS];
  logic [CA_PINS-1:0] fail_q;

  logic [3:0]         pin;
  logic [SLOT_W-1:0]  slot;
  logic [CA_PINS-1:0] pin_oh;
  logic               sample, slot_ok, found;
  logic [TAP_W-1:0]   win_first, win_last;
  logic [TAP_W:0]     win_sum;

  assign pin     = seq_pin(idx_q);
  assign slot    = seq_slot(idx_q);
  assign pin_oh  = CA_PINS'(1) << pin;
  assign sample  = (state_q == S_DRIVE) && (cnt_q == SETTLE_CYC[CNT_W-1:0]);
  assign win_sum = {1'b0, win_first} + {1'b0, win_last};

  ca_slot_compare #(.DQ_W(DQ_W), .SLOT_W(SLOT_W)) u_cmp (
    .dq_i    (dq_i),
    .slot_i  (slot),
    .rise_i  (~phase_q),
    .fall_i  (phase_q),
    .match_o (slot_ok)
  );

  ca_window_track #(.TAP_W(TAP_W)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == S_STORE || state_q == S_ENTER),
    .step_i  (sample && phase_q),
    .pass_i  (ph_ok_q && slot_ok),
    .tap_i   (tap_q),
    .found_o (found),
    .first_o (win_first),
    .last_o  (win_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      tap_q   <= '0;
      phase_q <= 1'b0;
      ph_ok_q <= 1'b0;
      cnt_q   <= '0;
      fail_q  <= '0;
      for (int i = 0; i < CA_PINS; i++) center_q[i] <= TAP_DEF;
    end else begin
      case (state_q)
        S_IDLE, S_DONE: if (start_i) state_q <= S_ENTER;
        S_ENTER: begin
          idx_q   <= '0;
          tap_q   <= '0;
          phase_q <= 1'b0;
          cnt_q   <= '0;
          state_q <= S_DRIVE;
        end
        S_DRIVE: begin
          if (!sample) begin
            cnt_q <= cnt_q + 1'b1;
          end else begin
            cnt_q <= '0;
            if (!phase_q) begin
              ph_ok_q <= slot_ok;
              phase_q <= 1'b1;
            end else begin
              phase_q <= 1'b0;
              if (tap_q == '1) state_q <= S_STORE;
              else             tap_q   <= tap_q + 1'b1;
            end
          end
        end
        S_STORE: begin
          center_q[pin] <= found ? win_sum[TAP_W:1] : TAP_DEF;
          fail_q[pin]   <= !found;
          tap_q         <= '0;
          if (idx_q == 4'(SESS1_PINS - 1))   state_q <= S_REMAP;
          else if (idx_q == 4'(CA_PINS - 1)) state_q <= S_EXIT;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_DRIVE;
          end
        end
        S_REMAP: begin
          idx_q   <= 4'(SESS1_PINS);
          state_q <= S_DRIVE;
        end
        S_EXIT:  state_q <= S_DONE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_op_o   = OP_NOP;
    cmd_mr_o   = '0;
    tap_o      = TAP_DEF;
    pat_rise_o = '0;
    pat_fall_o = '0;
    case (state_q)
      S_ENTER: begin cmd_op_o = OP_MRW; cmd_mr_o = MR_ENTER; end
      S_REMAP: begin cmd_op_o = OP_MRW; cmd_mr_o = MR_REMAP; end
      S_EXIT:  begin cmd_op_o = OP_MRW; cmd_mr_o = MR_EXIT;  end
      S_DRIVE: begin
        cmd_op_o   = OP_TRAIN;
        tap_o      = tap_q;
        pat_rise_o = phase_q ? '0 : pin_oh;
        pat_fall_o = phase_q ? pin_oh : '0;
      end
      default: ;
    endcase
    // command words are edge-symmetric so any tap captures them
    if (cmd_op_o == OP_MRW) begin
      pat_rise_o = CA_PINS'(cmd_mr_o);
      pat_fall_o = CA_PINS'(cmd_mr_o);
    end
  end

  assign done_o = (state_q == S_DONE);
  assign fail_o = fail_q;
  for (genvar g = 0; g < CA_PINS; g++) begin : g_out
    assign center_o[g*TAP_W +: TAP_W] = center_q[g];
  end

  p_mrw_edges_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_op_o == OP_MRW) |-> (pat_rise_o == pat_fall_o));

  p_one_pin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_op_o == OP_TRAIN) |->
      ($countones(pat_rise_o | pat_fall_o) == 1 && (pat_rise_o & pat_fall_o) == '0));

  p_settle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DRIVE && cnt_q != '0) |->
      ($stable(tap_o) && $stable(pat_rise_o) && $stable(pat_fall_o)));

  p_done_after_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(cmd_op_o) == OP_MRW && $past(cmd_mr_o) == MR_EXIT));

  p_enter_from_rest_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_op_o == OP_MRW && cmd_mr_o == MR_ENTER) |->
      ($past(done_o) || $past(state_q == S_IDLE)));
endmodule

// File: tb/ca_train_seq_bench.sv
module ca_train_seq_bench;
  localparam int SETTLE = 3;
  localparam int NP = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] dq;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_mr;
  logic [4:0]  tap;
  logic [9:0]  p_rise, p_fall, fail;
  logic        done;
  logic [49:0] center;

  int vec = 0, err = 0;
  logic [31:0] ev_m [NP];
  logic [31:0] od_m [NP];

  always #2.5 clk = ~clk;

  ca_train_seq #(.TAP_W(5), .SETTLE_CYC(SETTLE), .DEF_TAP(16)) u_ca_train_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dq_i(dq),
    .cmd_op_o(cmd_op), .cmd_mr_o(cmd_mr), .tap_o(tap),
    .pat_rise_o(p_rise), .pat_fall_o(p_fall), .done_o(done),
    .center_o(center), .fail_o(fail)
  );

  // memory model: data valid only after the pattern settled
  logic [24:0] snap, prev_snap;
  int age = 0, age_eff;
  logic remap = 1'b0;
  assign snap = {tap, p_rise, p_fall};
  assign age_eff = (snap != prev_snap) ? 0 : age;

  always @(posedge clk) begin
    if (snap != prev_snap) age <= 1;
    else if (age < 100) age <= age + 1;
    prev_snap <= snap;
  end

  function automatic int slot_of(int p, logic rm);
    int s1 [8] = '{0, 1, 2, 3, 5, 6, 7, 8};
    if (rm) return (p == 4) ? 0 : (p == 9) ? 1 : -1;
    for (int i = 0; i < 8; i++) if (s1[i] == p) return i;
    return -1;
  endfunction

  always_comb begin
    int p, s;
    logic eo, oo;
    dq = '0;
    p = -1;
    for (int i = 0; i < NP; i++) if (p_rise[i] || p_fall[i]) p = i;
    if (cmd_op == 2'd2 && p >= 0) begin
      s = slot_of(p, remap);
      if (s >= 0) begin
        eo = ev_m[p][tap] && (age_eff >= SETTLE);
        oo = od_m[p][tap] && (age_eff >= SETTLE);
        dq[2*s]   = eo ? p_rise[p] : ~p_rise[p];
        dq[2*s+1] = oo ? p_fall[p] : ~p_fall[p];
      end
    end
  end

  // command monitor
  int mr_log [8];
  int mr_n = 0, pin_log [16], pin_n = 0, last_pin = -1, ord_err = 0;
  int exp_tap = 0, exp_ph = 0;
  logic [24:0] mon_snap = '0;
  always @(negedge clk) begin
    int p;
    if (cmd_op == 2'd1) begin
      if (mr_n < 8) mr_log[mr_n] = int'(cmd_mr);
      mr_n++;
      if (cmd_mr == 8'd41) remap = 1'b0;
      if (cmd_mr == 8'd48) remap = 1'b1;
    end
    if (cmd_op == 2'd2 && snap != mon_snap) begin
      p = -1;
      for (int i = 0; i < NP; i++) if (p_rise[i] || p_fall[i]) p = i;
      if (p != last_pin) begin
        if (pin_n < 16) pin_log[pin_n] = p;
        pin_n++;
        last_pin = p;
        exp_tap = 0;
        exp_ph = 0;
      end
      if (int'(tap) != exp_tap) ord_err++;
      if (exp_ph == 0 && !(p_rise[p] == 1'b1 && p_fall == '0)) ord_err++;
      if (exp_ph == 1 && !(p_fall[p] == 1'b1 && p_rise == '0)) ord_err++;
      if (exp_ph == 1) exp_tap++;
      exp_ph = 1 - exp_ph;
    end
    mon_snap = snap;
  end

  task automatic chk(string req, int act, int exp);
    vec++;
    if (act != exp) begin
      err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rng(int lo, int hi);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[i] = (i >= lo && i <= hi);
    return r;
  endfunction

  function automatic int exp_center(logic [31:0] m);
    int run = 0, st = 0, best = 0, bf = 0, bl = 0;
    for (int i = 0; i < 32; i++) begin
      if (m[i]) begin
        if (run == 0) st = i;
        run++;
        if (run > best) begin best = run; bf = st; bl = i; end
      end else run = 0;
    end
    return (best == 0) ? 16 : (bf + bl) / 2;
  endfunction

  task automatic run_and_check(string tag, bit busy_start);
    int order [10] = '{0, 1, 2, 3, 5, 6, 7, 8, 4, 9};
    int cyc = 0;
    mr_n = 0; pin_n = 0; last_pin = -1; ord_err = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (busy_start && cyc == 500) start = 1'b1;
      if (busy_start && cyc == 501) start = 1'b0;
    end
    @(negedge clk);
    chk({tag, " R5 done"}, int'(done), 1);
    chk({tag, " R5 nop while done"}, int'(cmd_op), 0);
    chk({tag, " R12 mrw count"}, mr_n, 3);
    chk({tag, " R2 enter mr41"}, mr_log[0], 41);
    chk({tag, " R4 remap mr48"}, mr_log[1], 48);
    chk({tag, " R5 exit mr42"}, mr_log[2], 42);
    chk({tag, " R7 order/phase"}, ord_err, 0);
    chk({tag, " R3 R4 pin count"}, pin_n, 10);
    for (int i = 0; i < 10; i++) chk({tag, " R3 R4 pin order"}, pin_log[i], order[i]);
    // R8 R9 R10 R11: centres depend on settled, two-line, two-phase passes
    for (int p = 0; p < NP; p++) begin
      chk({tag, " R10 centre"}, int'(center[p*5 +: 5]), exp_center(ev_m[p] & od_m[p]));
      chk({tag, " R11 fail"}, int'(fail[p]), int'((ev_m[p] & od_m[p]) == '0));
    end
  endtask

  task automatic t_reset;
    chk("R1 done", int'(done), 0);
    chk("R1 cmd", int'(cmd_op), 0);
    chk("R1 fail", int'(fail), 0);
    for (int p = 0; p < NP; p++) chk("R1 centre", int'(center[p*5 +: 5]), 16);
  endtask

  task automatic t_mixed_windows;
    ev_m[0] = rng(8, 20);  od_m[0] = rng(8, 20);
    ev_m[1] = rng(0, 31);  od_m[1] = rng(0, 31);
    ev_m[2] = '0;          od_m[2] = rng(0, 31);           // R11 no window
    ev_m[3] = rng(2, 4) | rng(10, 14); od_m[3] = ev_m[3];  // R10 later run longer
    ev_m[4] = rng(5, 9) | rng(20, 24); od_m[4] = ev_m[4];  // R10 tie -> earliest
    ev_m[5] = rng(0, 31);  od_m[5] = rng(10, 12);          // R9 odd line narrower
    ev_m[6] = rng(31, 31); od_m[6] = rng(31, 31);
    ev_m[7] = rng(0, 0);   od_m[7] = rng(0, 0);
    ev_m[8] = rng(3, 6);   od_m[8] = rng(3, 6);            // R10 rounds down
    ev_m[9] = rng(25, 30); od_m[9] = rng(25, 30);
    run_and_check("mixed", 1'b0);
  endtask

  task automatic t_rerun_busy_start;
    for (int p = 0; p < NP; p++) begin
      ev_m[p] = rng(p, p + 11);
      od_m[p] = rng(p + 1, p + 12);
    end
    run_and_check("rerun", 1'b1);  // R11 fail of CA2 clears, R12 start ignored
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin ev_m[p] = '0; od_m[p] = '0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_mixed_windows();
    t_rerun_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end
endmodule